// File: doc/BRIEF.md
# Scanline Timing Generator

This block turns elapsed master-clock cycles into video-clock timing. Each step request carries a count of master cycles. The block scales that count by 11/7 to get video ticks and keeps the leftover fraction, so nothing is lost across steps. It adds the ticks to a position inside the current scanline. It then folds the position back into whole scanlines, retiring one scanline per clock cycle, and raises `busy` while it does so.

With each retired scanline the block advances the line number. It re-evaluates the vertical blanking flag and updates the line-parity status bit. When the line number reaches the frame length, the line number returns to zero and a frame-end pulse is issued.

The video standard sets the scanline length and the frame length. The vertical mode selects how the parity bit behaves. A vertical display range register holds the first and last visible lines, and together they set where blanking starts. A host steps the block from its own scheduler and watches the pulses to schedule its next event.

Top module: `scan_timing_gen`

## Requirements
- R1: During reset and straight after it, the tick position, line number, fraction, vblank, both pulses, parity bit and `busy` are all 0. The range register loads the parameter `VRANGE_RST`.
- R2: A step of n cycles is accepted only while `busy` is 0. One cycle after acceptance, the tick position has grown by floor((n*11 + f)/7) and the fraction equals (n*11 + f) mod 7, where f is the old fraction. The fraction is always below 7.
- R3: With `std_pal`=0 a scanline is `NTSC_LEN` ticks (default 3413) and a frame is `NTSC_LINES` lines (default 263). With `std_pal`=1 they are `PAL_LEN` (3406) and `PAL_LINES` (314). The inputs are sampled on the cycle that uses them.
- R4: After accepting a step, the block holds `busy` at 1 and retires one scanline per cycle. Each retirement subtracts the scanline length and adds 1 to the line number. The block drops `busy` on the first cycle whose decision finds the position below the scanline length.
- R5: When the incremented line number is at or above the frame length, the line number becomes 0 instead. In the same cycle `frame_end` is 1, and only for that cycle.
- R6: On each retirement, vblank is set to (incremented line, before any wrap) >= Y2 - Y1 + 1. This value is computed in 11 bits. `vblank_start` is 1 for one cycle only when vblank goes from 0 to 1.
- R7: With `vmode_480`=1, the parity bit inverts at each frame wrap and holds at all other retirements.
- R8: With `vmode_480`=0, the parity bit equals bit 0 of the new line number after every retirement, including a wrap to 0.
- R9: A write with `vrange_we` keeps only bits 19:0 of `vrange_wdata`. Y1 is bits 9:0 and Y2 is bits 19:10. Bits 31:20 have no effect. The new range applies from the next retirement.
- R10: A step request while `busy` is 1 is ignored. Changing the standard, the vertical mode or the range never resets the position, line, fraction or parity bit.
- R11: While the block is idle and no step is requested, the tick position, line number and fraction hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | Step request, taken while idle |
| step_cycles | input | CYC_W | Master cycles elapsed in this step |
| std_pal | input | 1 | 1 selects the 50 Hz line and frame lengths |
| vmode_480 | input | 1 | 1 selects 480-line parity behaviour |
| vrange_we | input | 1 | Write strobe for the vertical range |
| vrange_wdata | input | 32 | Vertical range data; Y1 in 9:0, Y2 in 19:10 |
| busy | output | 1 | Scanlines still being retired |
| tick_pos | output | ACC_W | Tick position within the scanline |
| line_num | output | LINE_W | Current scanline number |
| frac_rem | output | 3 | Fraction carried between steps |
| vblank | output | 1 | Vertical blanking flag |
| vblank_start | output | 1 | One-cycle pulse on blanking entry |
| frame_end | output | 1 | One-cycle pulse on frame wrap |
| even_line | output | 1 | Line-parity status bit |

ACC_W = max(CYC_W, TICK_W) + 3.

## Verification
The bench builds the block with `CYC_W`=8, 40- and 33-tick scanlines, and 12- and 15-line frames. The reset range puts the first visible line at 1 and the last at 8, which gives 8 visible lines. At these sizes one step of up to 255 cycles spans about ten scanlines. That brings many consecutive retirements, frame wraps, blanking entries and standard switches mid-line into a few thousand cycles.

The bench writes range values that make blanking start earlier, later or never. It also writes data with junk in the upper bits, and it holds step requests high while the block is busy.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;
    localparam int unsigned RATIO_MUL = 11;
    localparam int unsigned RATIO_DIV = 7;
    localparam int unsigned FRAC_W    = 3;
    localparam int unsigned YFIELD_W  = 10;
    localparam int unsigned VRANGE_W  = 2 * YFIELD_W;
    localparam int unsigned VIS_W     = YFIELD_W + 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;
endpackage

// File: rtl/scan_ratio_conv.sv
module scan_ratio_conv
    import scan_timing_pkg::*;
#(
    parameter int unsigned CYC_W = 16,
    parameter int unsigned ACC_W = 19
) (
    input  logic [CYC_W-1:0]  cycles,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [ACC_W-1:0]  ticks_add,
    output logic [FRAC_W-1:0] frac_out
);
    localparam int unsigned PROD_W = CYC_W + $clog2(RATIO_MUL) + 1;

    logic [PROD_W-1:0] scaled;
    logic [PROD_W-1:0] quot;
    logic [PROD_W-1:0] rem;

    always_comb begin
        scaled    = PROD_W'(cycles) * PROD_W'(RATIO_MUL) + PROD_W'(frac_in);
        quot      = scaled / PROD_W'(RATIO_DIV);
        rem       = scaled % PROD_W'(RATIO_DIV);
        ticks_add = ACC_W'(quot);
        frac_out  = FRAC_W'(rem);
    end
endmodule

// File: rtl/scan_std_sel.sv
module scan_std_sel #(
    parameter int unsigned TICK_W     = 12,
    parameter int unsigned LINE_W     = 9,
    parameter int unsigned NTSC_LEN   = 3413,
    parameter int unsigned NTSC_LINES = 263,
    parameter int unsigned PAL_LEN    = 3406,
    parameter int unsigned PAL_LINES  = 314
) (
    input  logic              std_pal,
    output logic [TICK_W-1:0] line_len,
    output logic [LINE_W:0]   frame_lines
);
    always_comb begin
        if (std_pal) begin
            line_len    = TICK_W'(PAL_LEN);
            frame_lines = (LINE_W+1)'(PAL_LINES);
        end else begin
            line_len    = TICK_W'(NTSC_LEN);
            frame_lines = (LINE_W+1)'(NTSC_LINES);
        end
    end
endmodule

// File: rtl/scan_vrange_reg.sv
module scan_vrange_reg
    import scan_timing_pkg::*;
#(
    parameter logic [VRANGE_W-1:0] VRANGE_RST = 20'h3FC10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [VRANGE_W-1:0] wr_data,
    output logic [VIS_W-1:0]    vis_lines
);
    logic [VRANGE_W-1:0] range_q;
    logic [YFIELD_W-1:0] first_ln;
    logic [YFIELD_W-1:0] last_ln;

    always_ff @(posedge clk) begin
        if (!rst_n)     range_q <= VRANGE_RST;
        else if (wr_en) range_q <= wr_data;
    end

    always_comb begin
        first_ln  = range_q[YFIELD_W-1:0];
        last_ln   = range_q[VRANGE_W-1:YFIELD_W];
        vis_lines = {1'b0, last_ln} - {1'b0, first_ln} + VIS_W'(1);
    end
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
    import scan_timing_pkg::*;
#(
    parameter int unsigned CYC_W      = 16,
    parameter int unsigned TICK_W     = 12,
    parameter int unsigned LINE_W     = 9,
    parameter int unsigned NTSC_LEN   = 3413,
    parameter int unsigned NTSC_LINES = 263,
    parameter int unsigned PAL_LEN    = 3406,
    parameter int unsigned PAL_LINES  = 314,
    parameter logic [19:0] VRANGE_RST = 20'h3FC10,
    localparam int unsigned ACC_W     = ((CYC_W > TICK_W) ? CYC_W : TICK_W) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_valid,
    input  logic [CYC_W-1:0]  step_cycles,
    input  logic              std_pal,
    input  logic              vmode_480,
    input  logic              vrange_we,
    input  logic [31:0]       vrange_wdata,
    output logic              busy,
    output logic [ACC_W-1:0]  tick_pos,
    output logic [LINE_W-1:0] line_num,
    output logic [2:0]        frac_rem,
    output logic              vblank,
    output logic              vblank_start,
    output logic              frame_end,
    output logic              even_line
);
    scan_state_e state_q, state_d;

    logic [ACC_W-1:0]  ticks_add;
    logic [FRAC_W-1:0] frac_next;
    logic [TICK_W-1:0] line_len;
    logic [LINE_W:0]   frame_lines;
    logic [VIS_W-1:0]  vis_lines;
    logic [LINE_W:0]   line_inc;
    logic              need_adv;
    logic              wraps;
    logic              vb_next;
    logic              unused_hi_bits;

    assign unused_hi_bits = ^vrange_wdata[31:VRANGE_W];

    scan_ratio_conv #(.CYC_W(CYC_W), .ACC_W(ACC_W)) u_conv (
        .cycles    (step_cycles),
        .frac_in   (frac_rem),
        .ticks_add (ticks_add),
        .frac_out  (frac_next)
    );

    scan_std_sel #(
        .TICK_W(TICK_W), .LINE_W(LINE_W),
        .NTSC_LEN(NTSC_LEN), .NTSC_LINES(NTSC_LINES),
        .PAL_LEN(PAL_LEN), .PAL_LINES(PAL_LINES)
    ) u_std (
        .std_pal     (std_pal),
        .line_len    (line_len),
        .frame_lines (frame_lines)
    );

    scan_vrange_reg #(.VRANGE_RST(VRANGE_RST)) u_vrange (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (vrange_we),
        .wr_data   (vrange_wdata[VRANGE_W-1:0]),
        .vis_lines (vis_lines)
    );

    always_comb begin
        line_inc = {1'b0, line_num} + (LINE_W+1)'(1);
        need_adv = tick_pos >= ACC_W'(line_len);
        wraps    = 32'(line_inc) >= 32'(frame_lines);
        vb_next  = 32'(line_inc) >= 32'(vis_lines);
        busy     = (state_q == ST_SCAN);
    end

    // Transitions: IDLE->SCAN on an accepted step; SCAN->IDLE once the position fits a line.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (step_valid) state_d = ST_SCAN;
            ST_SCAN: if (!need_adv)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_pos     <= '0;
            line_num     <= '0;
            frac_rem     <= '0;
            vblank       <= 1'b0;
            vblank_start <= 1'b0;
            frame_end    <= 1'b0;
            even_line    <= 1'b0;
        end else begin
            vblank_start <= 1'b0;
            frame_end    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (step_valid) begin
                        tick_pos <= tick_pos + ticks_add;
                        frac_rem <= frac_next;
                    end
                end
                ST_SCAN: begin
                    if (need_adv) begin
                        tick_pos     <= tick_pos - ACC_W'(line_len);
                        vblank       <= vb_next;
                        vblank_start <= vb_next & ~vblank;
                        if (wraps) begin
                            line_num  <= '0;
                            frame_end <= 1'b1;
                            even_line <= vmode_480 ? ~even_line : 1'b0;
                        end else begin
                            line_num  <= line_inc[LINE_W-1:0];
                            even_line <= vmode_480 ? even_line : line_inc[0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/scan_timing_gen_chk.sv
module scan_timing_gen_chk #(
    parameter int unsigned ACC_W    = 19,
    parameter int unsigned LINE_W   = 9,
    parameter int unsigned NTSC_LEN = 3413,
    parameter int unsigned PAL_LEN  = 3406
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_valid,
    input logic              std_pal,
    input logic              vmode_480,
    input logic              busy,
    input logic [ACC_W-1:0]  tick_pos,
    input logic [LINE_W-1:0] line_num,
    input logic [2:0]        frac_rem,
    input logic              vblank,
    input logic              vblank_start,
    input logic              frame_end,
    input logic              even_line
);
    assert_frac_below_seven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frac_rem < 3'd7);

    assert_fits_line_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (tick_pos < ($past(std_pal) ? ACC_W'(PAL_LEN) : ACC_W'(NTSC_LEN))));

    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (line_num == '0));

    assert_vbl_edge_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_start |-> (vblank && !$past(vblank)));

    assert_parity_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && $past(vmode_480)) |-> (even_line != $past(even_line)));

    assert_parity_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(vmode_480) && (line_num != $past(line_num))) |-> (even_line == line_num[0]));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && !$past(step_valid)) |-> ($stable(tick_pos) && $stable(line_num) && $stable(frac_rem)));
endmodule

bind scan_timing_gen scan_timing_gen_chk #(
    .ACC_W(ACC_W), .LINE_W(LINE_W), .NTSC_LEN(NTSC_LEN), .PAL_LEN(PAL_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .std_pal(std_pal),
    .vmode_480(vmode_480), .busy(busy), .tick_pos(tick_pos), .line_num(line_num),
    .frac_rem(frac_rem), .vblank(vblank), .vblank_start(vblank_start),
    .frame_end(frame_end), .even_line(even_line)
);

// File: tb/scan_timing_gen_test.sv
`timescale 1ns/1ps
module scan_timing_gen_test;
    localparam int CYC_W = 8;
    localparam int TICK_W = 6;
    localparam int LINE_W = 4;
    localparam int N_LEN = 40;
    localparam int N_LINES = 12;
    localparam int P_LEN = 33;
    localparam int P_LINES = 15;
    localparam logic [19:0] RANGE0 = 20'h02001;
    localparam int ACC_W = ((CYC_W > TICK_W) ? CYC_W : TICK_W) + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_valid = 1'b0;
    logic [CYC_W-1:0] step_cycles = '0;
    logic std_pal = 1'b0;
    logic vmode_480 = 1'b0;
    logic vrange_we = 1'b0;
    logic [31:0] vrange_wdata = '0;
    logic busy, vblank, vblank_start, frame_end, even_line;
    logic [ACC_W-1:0] tick_pos;
    logic [LINE_W-1:0] line_num;
    logic [2:0] frac_rem;

    int n_chk = 0;
    int n_fail = 0;
    int n_frames = 0;
    int n_vbs = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scan_timing_gen #(
        .CYC_W(CYC_W), .TICK_W(TICK_W), .LINE_W(LINE_W),
        .NTSC_LEN(N_LEN), .NTSC_LINES(N_LINES), .PAL_LEN(P_LEN), .PAL_LINES(P_LINES),
        .VRANGE_RST(RANGE0)
    ) uut (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_cycles(step_cycles),
        .std_pal(std_pal), .vmode_480(vmode_480), .vrange_we(vrange_we),
        .vrange_wdata(vrange_wdata), .busy(busy), .tick_pos(tick_pos),
        .line_num(line_num), .frac_rem(frac_rem), .vblank(vblank),
        .vblank_start(vblank_start), .frame_end(frame_end), .even_line(even_line)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced at each rising edge
    int m_tick, m_frac, m_line, m_vb, m_vs, m_fe, m_even, m_busy, m_y1, m_y2;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tick = 0; m_frac = 0; m_line = 0; m_vb = 0; m_vs = 0; m_fe = 0;
            m_even = 0; m_busy = 0;
            m_y1 = int'(RANGE0[9:0]); m_y2 = int'(RANGE0[19:10]);
        end else begin
            int len, tot, vis, t;
            len = std_pal ? P_LEN : N_LEN;
            tot = std_pal ? P_LINES : N_LINES;
            vis = (m_y2 - m_y1 + 1) & 2047;
            m_vs = 0; m_fe = 0;
            if (m_busy == 0) begin
                if (step_valid) begin
                    t = int'(step_cycles) * 11 + m_frac;
                    m_tick = m_tick + t / 7;
                    m_frac = t % 7;
                    m_busy = 1;
                end
            end else if (m_tick >= len) begin
                m_tick = m_tick - len;
                m_line = m_line + 1;
                if (m_line >= vis && m_vb == 0) m_vs = 1;
                m_vb = (m_line >= vis) ? 1 : 0;
                if (m_line >= tot) begin
                    m_fe = 1;
                    m_line = 0;
                    if (vmode_480) m_even = 1 - m_even;
                end
                if (!vmode_480) m_even = m_line & 1;
            end else begin
                m_busy = 0;
            end
            if (vrange_we) begin
                m_y1 = int'(vrange_wdata[9:0]);
                m_y2 = int'(vrange_wdata[19:10]);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 busy", int'(busy), m_busy);
            chk("R2 tick_pos", int'(tick_pos), m_tick);
            chk("R2 frac_rem", int'(frac_rem), m_frac);
            chk("R5 line_num", int'(line_num), m_line);
            chk("R6 vblank", int'(vblank), m_vb);
            chk("R6 vblank_start", int'(vblank_start), m_vs);
            chk("R5 frame_end", int'(frame_end), m_fe);
            chk(vmode_480 ? "R7 even_line" : "R8 even_line", int'(even_line), m_even);
            if (frame_end) n_frames++;
            if (vblank_start) n_vbs++;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_step(input int n);
        @(negedge clk);
        step_valid = 1'b1;
        step_cycles = CYC_W'(n);
        @(negedge clk);
        step_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic write_range(input logic [31:0] d);
        @(negedge clk);
        vrange_we = 1'b1;
        vrange_wdata = d;
        @(negedge clk);
        vrange_we = 1'b0;
    endtask

    initial begin
        #20000000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 tick_pos", int'(tick_pos), 0);
        chk("R1 line_num", int'(line_num), 0);
        chk("R1 frac_rem", int'(frac_rem), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 vblank", int'(vblank), 0);
        chk("R1 even_line", int'(even_line), 0);
        rst_n = 1'b1;

        // R2: fractional carry, 11 -> 1 r4, then 15 -> 2 r1
        do_step(1);
        chk("R2 first step tick", int'(tick_pos), 1);
        chk("R2 first step frac", int'(frac_rem), 4);
        do_step(1);
        chk("R2 second step tick", int'(tick_pos), 3);
        chk("R2 second step frac", int'(frac_rem), 1);

        // R11: idle without request holds
        repeat (5) @(negedge clk);
        chk("R11 idle tick", int'(tick_pos), 3);

        // R3/R4/R5/R6/R8: 240-line mode, standard lengths, varied step sizes
        for (int i = 0; i < 40; i++) do_step((i * 37 + 5) % 256);

        // R10: requests held high while busy are ignored
        @(negedge clk);
        step_valid = 1'b1;
        step_cycles = 8'd255;
        repeat (30) @(negedge clk);
        step_valid = 1'b0;
        wait_idle();

        // R7: 480-line parity
        vmode_480 = 1'b1;
        for (int i = 0; i < 40; i++) do_step((i * 53 + 11) % 256);

        // R3/R10: switch to the 50 Hz standard mid-frame, position kept
        std_pal = 1'b1;
        for (int i = 0; i < 30; i++) do_step((i * 29 + 17) % 256);

        // R9: upper junk bits ignored; Y1=3, Y2=11
        write_range(32'hFFF0_2C03);
        vmode_480 = 1'b0;
        for (int i = 0; i < 30; i++) do_step((i * 71 + 3) % 256);

        // R6: visible count above frame length, blanking never entered
        write_range(32'h0000_5000);
        std_pal = 1'b0;
        for (int i = 0; i < 30; i++) do_step((i * 13 + 40) % 256);
        chk("R6 vblank stays low", int'(vblank), 0);

        // R9: early blanking, Y1=Y2=2 gives one visible line
        write_range(32'h0000_0802);
        for (int i = 0; i < 20; i++) do_step(200);

        chk("R5 frames seen", int'(n_frames > 10), 1);
        chk("R6 blank entries seen", int'(n_vbs > 5), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule